// File: doc/BRIEF.md
# Station Address Store Host Access Decoder

This block sits between a host bus and a network controller. It holds a 16-byte store whose first six bytes carry the station (MAC) address, and it routes every host access either to that store or to the controller's register window. Two access paths share a single request port. On the port-mapped path, the size of an access and the alignment the store accepts depend on a dword-mode configuration bit. On the memory-mapped path, address bit 4 picks the target and any size reaches the store.

Reads that span several bytes are assembled little-endian from the byte store, and byte indices wrap inside 16 bytes. Writes are split into byte writes the same way and land only while a store write-enable bit is set. An access the block cannot serve returns all ones for its width, and a write in that case is dropped. Register-window accesses go out over a request/acknowledge port and are held there until the register file answers.

Top module: `prom_access_decoder`

## Requirements
- R1: After reset, store byte i (i = 0..5) equals STATION_ADDR[8i+7:8i] and bytes 6..15 are zero. After reset rsp_valid is low and req_ready is high.
- R2: On the port-mapped path (req_mmio = 0), offsets below 16 address the store. Offsets of 16 and above go to the register window, with the full offset on reg_addr.
- R3: Size codes on req_size are 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = reserved. On the port-mapped path with cfg_dword_io = 0, the store accepts bytes at any offset and 16-bit accesses at even offsets. With cfg_dword_io = 1 it accepts only 32-bit accesses at offsets that are a multiple of 4.
- R4: A rejected access returns 0xFF for a byte, 0xFFFF for 16 bits and 0xFFFFFFFF for 32 bits or the reserved code, and a rejected write changes nothing and starts no register access. A rejected access is one the store does not accept, a register-window access that is not 16 or 32 bits, or any access with the reserved size code.
- R5: Multi-byte store reads put the byte at index base in bits 7:0 and the byte at index base+k in bits 8k+7:8k. Indices are taken modulo 16, and unused upper bits are zero.
- R6: Store writes put data bits 8k+7:8k into the byte at index (base+k) mod 16, and only when cfg_prom_we = 1. With cfg_prom_we = 0 the store does not change.
- R7: On the memory-mapped path (req_mmio = 1), address bit 4 clear selects the store at index address bits 3:0 for any non-reserved size at any alignment. Bit 4 set selects the register window, and reg_addr then carries address bits 3:0 with its upper bits zero. Address bits above 4 are ignored.
- R8: On the memory-mapped path, byte accesses to the register window never raise reg_req. Such reads return 0xFF and such writes are dropped.
- R9: A store or rejected access gets its response (rsp_valid) in the cycle after it is accepted. A forwarded access holds reg_req with stable reg_addr, reg_wide (1 = 32-bit, 0 = 16-bit), reg_write and reg_wdata until reg_ack. Its response follows one cycle after the acknowledge and carries reg_rdata on reads, while req_ready stays low until then. A write response carries zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prom_we | input | 1 | Store write enable |
| cfg_dword_io | input | 1 | Port-mapped dword mode |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Request accepted at this edge when high |
| req_mmio | input | 1 | 1 = memory-mapped path, 0 = port-mapped path |
| req_addr | input | ADDR_W | Access offset |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| reg_req | output | 1 | Register-window request, held until reg_ack |
| reg_addr | output | ADDR_W | Register-window offset |
| reg_wide | output | 1 | 1 = 32-bit, 0 = 16-bit |
| reg_write | output | 1 | Register-window write |
| reg_wdata | output | 32 | Register-window write data |
| reg_ack | input | 1 | Register file acknowledge |
| reg_rdata | input | 32 | Register file read data |

## Verification
Every port-mapped store offset is read with every size code in both dword modes. This separates the accepted combinations from the rejected ones, and the width of the all-ones fill shows which case was taken. Write sweeps run over the same grid with distinct data per offset and size, and after each write the whole store is read back. This exposes wrong lanes, a missing index wrap and bytes written outside the access. Memory-mapped addresses 0 to 63 are swept to check the bit-4 steering and that bit 5 has no effect. Register-window traffic uses acknowledge delays of 0 to 2 cycles to check the forwarded fields, the response latency and that byte accesses are dropped.

// File: rtl/prom_access_decoder.sv
module prom_access_decoder #(
  parameter int          ADDR_W       = 8,
  parameter logic [47:0] STATION_ADDR = 48'h00_00_00_00_00_00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_prom_we,
  input  logic              cfg_dword_io,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mmio,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              reg_req,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wide,
  output logic              reg_write,
  output logic [31:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [31:0]       reg_rdata
);
  localparam int NBYTES = 16;
  localparam int IDX_W  = $clog2(NBYTES);

  logic [NBYTES-1:0][7:0] prom;
  logic                   waiting;

  logic accept, is_byte, is_half, is_word;
  logic to_prom, prom_ok, reg_ok, to_reg;
  logic [IDX_W-1:0] base;
  logic [3:0]       lane_en;
  logic [31:0]      ones, prom_rd;
  logic [3:0][7:0]  lane_rd;

  assign req_ready = !waiting;
  assign reg_req   = waiting;
  assign accept    = req_valid && req_ready;

  assign is_byte = (req_size == 2'd0);
  assign is_half = (req_size == 2'd1);
  assign is_word = (req_size == 2'd2);

  assign to_prom = req_mmio ? !req_addr[4] : (req_addr < ADDR_W'(NBYTES));
  assign prom_ok = req_mmio ? (is_byte || is_half || is_word)
                 : cfg_dword_io ? (is_word && req_addr[1:0] == 2'b00)
                 : (is_byte || (is_half && !req_addr[0]));
  assign reg_ok  = is_half || is_word;
  assign to_reg  = !to_prom && reg_ok;

  assign base    = req_addr[IDX_W-1:0];
  assign lane_en = is_byte ? 4'b0001 : is_half ? 4'b0011 : 4'b1111;
  assign ones    = is_byte ? 32'h0000_00FF : is_half ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_rd[k] = lane_en[k] ? prom[base + IDX_W'(k)] : 8'h00;
  end
  assign prom_rd = lane_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++)
        prom[i] <= (i < 6) ? STATION_ADDR[8*i +: 8] : 8'h00;
    end else if (accept && req_write && to_prom && prom_ok && cfg_prom_we) begin
      for (int k = 0; k < 4; k++)
        if (lane_en[k]) prom[base + IDX_W'(k)] <= req_wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      reg_addr  <= '0;
      reg_wide  <= 1'b0;
      reg_write <= 1'b0;
      reg_wdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && to_reg) begin
        waiting   <= 1'b1;
        reg_addr  <= req_mmio ? ADDR_W'(req_addr[3:0]) : req_addr;
        reg_wide  <= is_word;
        reg_write <= req_write;
        reg_wdata <= req_wdata;
      end else if (accept) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= req_write ? 32'h0 : (to_prom && prom_ok) ? prom_rd : ones;
      end else if (waiting && reg_ack) begin
        waiting   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= reg_write ? 32'h0 : reg_rdata;
      end
    end
  end
endmodule

// File: rtl/prom_access_decoder_chk.sv
module prom_access_decoder_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_prom_we,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_mmio,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              reg_req,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wide,
  input logic              reg_write,
  input logic [31:0]       reg_wdata,
  input logic              reg_ack,
  input logic [31:0]       reg_rdata,
  input logic [127:0]      store
);
  assert_reply_or_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid != reg_req));

  assert_hold_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_wide)
                               && $stable(reg_write) && $stable(reg_wdata)));

  assert_return_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_ack && !reg_write) |=> (rsp_valid && rsp_rdata == $past(reg_rdata)));

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !req_ready);

  assert_store_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prom_we |=> $stable(store));

  assert_mmio_byte_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mmio && req_addr[4] && req_size == 2'd0 && !req_write)
      |=> (!reg_req && rsp_valid && rsp_rdata == 32'h0000_00FF));
endmodule

bind prom_access_decoder prom_access_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_prom_we(cfg_prom_we),
  .req_valid(req_valid), .req_ready(req_ready), .req_mmio(req_mmio),
  .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .reg_req(reg_req),
  .reg_addr(reg_addr), .reg_wide(reg_wide), .reg_write(reg_write),
  .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
  .store(prom)
);

// File: tb/prom_access_decoder_bench.sv
module prom_access_decoder_bench;
  localparam int          AW  = 8;
  localparam logic [47:0] MAC = 48'h6655_4433_2211;

  logic clk = 0, rst_n = 0;
  logic cfg_prom_we = 0, cfg_dword_io = 0;
  logic req_valid = 0, req_mmio = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, reg_req, reg_wide, reg_write;
  logic [31:0] rsp_rdata, reg_wdata;
  logic [AW-1:0] reg_addr;
  logic reg_ack = 0;
  logic [31:0] reg_rdata = '0;

  prom_access_decoder #(.ADDR_W(AW), .STATION_ADDR(MAC)) u_prom_access_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_prom_we(cfg_prom_we), .cfg_dword_io(cfg_dword_io),
    .req_valid(req_valid), .req_ready(req_ready), .req_mmio(req_mmio),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .reg_req(reg_req), .reg_addr(reg_addr), .reg_wide(reg_wide),
    .reg_write(reg_write), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int seen = 0, rdelay = 0, wcnt = 0;
  logic [AW-1:0] last_addr;
  logic last_wide, last_write;
  logic [31:0] last_wdata;
  logic [7:0] model [16];

  always @(negedge clk) begin
    if (reg_req && !reg_ack) begin
      if (wcnt >= rdelay) begin
        reg_ack = 1;
        reg_rdata = {16'hBEEF, reg_addr, 6'd0, reg_wide, reg_write};
        last_addr = reg_addr; last_wide = reg_wide;
        last_write = reg_write; last_wdata = reg_wdata;
        seen++; wcnt = 0;
      end else wcnt++;
    end else reg_ack = 0;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic mm, input int a, input int s, input logic wr,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1; req_mmio = mm; req_addr = AW'(a); req_size = 2'(s);
    req_write = wr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    rd = rsp_rdata;
  endtask

  function automatic logic [31:0] ones(input int s);
    return s == 0 ? 32'hFF : s == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] le_read(input int b, input int s);
    logic [31:0] v = 0;
    int n = s == 0 ? 1 : s == 1 ? 2 : 4;
    for (int k = 0; k < n; k++) v[8*k +: 8] = model[(b + k) % 16];
    return v;
  endfunction

  function automatic bit io_legal(input int dw, input int a, input int s);
    if (dw != 0) return s == 2 && a % 4 == 0;
    return s == 0 || (s == 1 && a % 2 == 0);
  endfunction

  task automatic le_write(input int b, input int s, input logic [31:0] wd);
    int n = s == 0 ? 1 : s == 1 ? 2 : 4;
    for (int k = 0; k < n; k++) model[(b + k) % 16] = wd[8*k +: 8];
  endtask

  task automatic verify_store(input string tag);
    logic [31:0] rd; int lat;
    for (int q = 0; q < 4; q++) begin
      access(1, 4*q, 2, 0, 0, rd, lat);
      chk(tag, rd, le_read(4*q, 2));
    end
  endtask

  initial begin : watchdog
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, wd, exp;
    int lat, s0;
    for (int i = 0; i < 16; i++) model[i] = i < 6 ? MAC[8*i +: 8] : 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 0);
    chk("R1 req_ready after reset", {31'd0, req_ready}, 1);
    for (int a = 0; a < 16; a++) begin
      access(0, a, 0, 0, 0, rd, lat);
      chk("R1 reset store byte", rd, le_read(a, 0));
    end

    // R3 R4 R5: port-mapped read sweep over both modes
    for (int dw = 0; dw < 2; dw++) begin
      cfg_dword_io = 1'(dw);
      for (int a = 0; a < 16; a++)
        for (int s = 0; s < 4; s++) begin
          access(0, a, s, 0, 0, rd, lat);
          exp = (s != 3 && io_legal(dw, a, s)) ? le_read(a, s) : ones(s);
          chk("R3/R4/R5 port read", rd, exp);
          if (a == 0) chk("R9 store latency", 32'(lat), 1);
        end
    end

    // R6: write enable clear leaves store unchanged
    cfg_prom_we = 0; cfg_dword_io = 0;
    access(0, 2, 1, 1, 32'h0000_A1B2, rd, lat);
    access(1, 8, 2, 1, 32'hDEAD_BEEF, rd, lat);
    verify_store("R6 locked store unchanged");

    // R6 R4: port-mapped write sweep with enable set
    cfg_prom_we = 1;
    for (int dw = 0; dw < 2; dw++) begin
      cfg_dword_io = 1'(dw);
      for (int a = 0; a < 16; a++)
        for (int s = 0; s < 4; s++) begin
          wd = 32'((a + 1) * 32'h0103_0507 + s * 32'h0001_0000 + dw * 32'h80);
          s0 = seen;
          access(0, a, s, 1, wd, rd, lat);
          if (s != 3 && io_legal(dw, a, s)) le_write(a, s, wd);
          chk("R4 no register access from store write", 32'(seen), 32'(s0));
          verify_store("R6 port write lanes");
        end
    end

    // R7 R8: memory-mapped read sweep, bit 5 ignored
    cfg_dword_io = 1;
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 4; s++) begin
        rdelay = a % 3;
        s0 = seen;
        access(1, a, s, 0, 0, rd, lat);
        if ((a & 16) == 0) begin
          chk("R7 mmio store read", rd, s == 3 ? ones(s) : le_read(a % 16, s));
        end else if (s == 1 || s == 2) begin
          chk("R7 mmio reg read data", rd, {16'hBEEF, 8'(a % 16), 6'd0, s == 2, 1'b0});
          chk("R7 mmio reg addr", {24'd0, last_addr}, 32'(a % 16));
          chk("R9 reg latency", 32'(lat), 32'(2 + rdelay));
        end else begin
          chk("R8 mmio byte/reserved reg read", rd, ones(s));
          chk("R8 no reg_req", 32'(seen), 32'(s0));
        end
      end

    // R5 R7: mmio writes at unaligned offsets wrap in 16 bytes
    access(1, 14, 2, 1, 32'hDDCC_BBAA, rd, lat);
    le_write(14, 2, 32'hDDCC_BBAA);
    verify_store("R5 wrap word write");
    access(1, 32 + 7, 1, 1, 32'h0000_5A6B, rd, lat);
    le_write(7, 1, 32'h0000_5A6B);
    verify_store("R7 odd half write bit5 ignored");
    access(1, 15, 2, 0, 0, rd, lat);
    chk("R5 wrap word read", rd, le_read(15, 2));
    s0 = seen;
    access(1, 16 + 3, 0, 1, 32'h77, rd, lat);
    chk("R8 mmio byte reg write dropped", 32'(seen), 32'(s0));
    verify_store("R8 store untouched");
    access(1, 16 + 6, 2, 1, 32'h1234_5678, rd, lat);
    chk("R7 mmio reg write data", last_wdata, 32'h1234_5678);
    chk("R9 write response zero", rd, 0);
    chk("R7 mmio reg write flag", {31'd0, last_write}, 1);

    // R2 R4: port-mapped register window
    for (int a = 16; a < 48; a++)
      for (int s = 0; s < 4; s++) begin
        rdelay = (a + s) % 3;
        s0 = seen;
        wd = 32'(a * 32'h0101_0101 + s);
        access(0, a, s, (a % 2) == 1, wd, rd, lat);
        if (s == 1 || s == 2) begin
          chk("R2 reg addr", {24'd0, last_addr}, 32'(a));
          chk("R9 reg wide", {31'd0, last_wide}, 32'(s == 2));
          if (a % 2 == 1) chk("R2 reg wdata", last_wdata, wd);
          else chk("R2 reg read", rd, {16'hBEEF, 8'(a), 6'd0, s == 2, 1'b0});
        end else begin
          chk("R4 port reg odd size dropped", 32'(seen), 32'(s0));
          if (a % 2 == 0) chk("R4 port reg ones", rd, ones(s));
        end
      end
    verify_store("R4 store after reg traffic");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule